// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block is the data path that sits between a 32-bit big-endian core and its data memory for every load and store. It receives a memory-access instruction word, the base register value, the current value of the source/destination register (rt) and the aligned memory word read at the access address. It forms the effective address and the aligned word address, extracts and extends load results, and builds the store word together with a per-lane byte-enable mask.

Besides the plain byte, halfword and word accesses, it supports the four unaligned merge operations. Load-left and load-right combine memory bytes with the old register contents. Store-left and store-right write part of the register into a word, depending on the byte offset. All results are registered. They appear one cycle after the access is presented. An unknown opcode causes no write of any kind and is reported on a one-cycle flag.

Top module: `lsAligner`

## Requirements
- R1: The instruction word is decoded as opcode = bits 31:26 and rt index = bits 20:16, and the immediate is bits 15:0. The effective address is the base value plus the sign-extended immediate. The word address is the effective address with bits 1:0 cleared. The byte offset k is effective address bits 1:0. The rt index is returned with the result.
- R2: Byte offset 0 is memory bits 31:24 and offset 3 is bits 7:0. The load byte opcode 0x20 returns the byte at offset k sign-extended to 32 bits. Opcode 0x24 returns it zero-extended.
- R3: Halfword load opcode 0x21 sign-extends and opcode 0x25 zero-extends. They return bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. Address bit 0 is ignored.
- R4: Word load opcode 0x23 returns the whole memory word, whatever the byte offset.
- R5: Load-left opcode 0x22 places memory bytes k..3 into the register starting at its most significant byte. The low k bytes of the old register value are kept.
- R6: Load-right opcode 0x26 places memory bytes 0..k into the low k+1 bytes of the register. The upper 3-k bytes of the old register value are kept.
- R7: byteEn bit i covers data bits 8i+7:8i, so offset k is enable bit 3-k. Store byte opcode 0x28 writes rt bits 7:0 into offset k and enables only that lane. Store halfword opcode 0x29 writes rt bits 15:0 into the half selected by address bit 1 and enables two lanes. Lanes that are not enabled carry the memory word unchanged.
- R8: Store word opcode 0x2b writes the whole rt word with all four lanes enabled. Store-left opcode 0x2a writes the high 4-k bytes of rt into offsets k..3 and enables exactly those lanes.
- R9: Store-right opcode 0x2e writes the low k+1 bytes of rt into offsets 0..k and enables exactly those lanes.
- R10: Any other opcode raises illegal for one cycle. It gives no register write, no memory write and an all-zero byte enable.
- R11: validOut is high exactly one cycle after each cycle with validIn high. When validOut is low, regWe, memWe, illegal and byteEn are all zero. Loads assert only regWe and stores assert only memWe.
- R12: A synchronous active-high reset clears validOut, regWe, memWe, illegal, byteEn and the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| validIn | input | 1 | an access is presented this cycle |
| insn | input | 32 | memory-access instruction word |
| baseVal | input | 32 | base register value |
| rtVal | input | 32 | current rt register value |
| memWord | input | 32 | aligned memory word at the access address |
| validOut | output | 1 | registered result valid |
| effAddr | output | 32 | effective byte address |
| wordAddr | output | 32 | aligned word address |
| rtIdx | output | 5 | destination/source register index |
| regWe | output | 1 | write regData to register rtIdx |
| regData | output | 32 | load result |
| memWe | output | 1 | write memData under byteEn |
| memData | output | 32 | merged store word |
| byteEn | output | 4 | store lane enables, bit i = bits 8i+7:8i |
| illegal | output | 1 | unsupported opcode pulse |

## Verification
Every access kind is run at several byte offsets: offset 0, 1, 2 and 3 where the operation depends on it. This separates a correct lane order from a mirrored one, and a correct merge boundary from an off-by-one boundary. The memory and register patterns use distinct bytes (0x12345678 against 0xaabbccdd, 0x11223344 for stores), so any wrong byte shows up as a foreign value in a named lane. Signed loads use values with the top bit set, to separate sign extension from zero extension. A negative immediate checks address formation. Unknown opcodes check that no write strobe leaks.

// File: rtl/lsAlignPkg.sv
package lsAlignPkg;
  localparam int XLEN   = 32;
  localparam int NBYTES = XLEN / 8;
  localparam int OFF_W  = $clog2(NBYTES);
  localparam int SH_W   = $clog2(XLEN);
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;
  localparam int RIDX_W = 5;

  localparam logic [OP_W-1:0] OP_LB  = 6'h20;
  localparam logic [OP_W-1:0] OP_LH  = 6'h21;
  localparam logic [OP_W-1:0] OP_LWL = 6'h22;
  localparam logic [OP_W-1:0] OP_LW  = 6'h23;
  localparam logic [OP_W-1:0] OP_LBU = 6'h24;
  localparam logic [OP_W-1:0] OP_LHU = 6'h25;
  localparam logic [OP_W-1:0] OP_LWR = 6'h26;
  localparam logic [OP_W-1:0] OP_SB  = 6'h28;
  localparam logic [OP_W-1:0] OP_SH  = 6'h29;
  localparam logic [OP_W-1:0] OP_SWL = 6'h2a;
  localparam logic [OP_W-1:0] OP_SW  = 6'h2b;
  localparam logic [OP_W-1:0] OP_SWR = 6'h2e;

  typedef enum logic [2:0] {
    KIND_BYTE,
    KIND_HALF,
    KIND_WORD,
    KIND_LEFT,
    KIND_RIGHT
  } accKind_e;

  typedef struct packed {
    logic     active;
    logic     loadEn;
    logic     storeEn;
    logic     signExt;
    logic     badOp;
    accKind_e kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/lsAlignCtrl.sv
module lsAlignCtrl
  import lsAlignPkg::*;
(
  input  logic            validIn,
  input  logic [OP_W-1:0] opcode,
  output ctrlStrobe_t     strobe
);
  always_comb begin
    strobe         = '0;
    strobe.kind    = KIND_WORD;
    strobe.active  = validIn;
    if (validIn) begin
      unique case (opcode)
        OP_LB:   begin strobe.loadEn  = 1'b1; strobe.kind = KIND_BYTE; strobe.signExt = 1'b1; end
        OP_LBU:  begin strobe.loadEn  = 1'b1; strobe.kind = KIND_BYTE; end
        OP_LH:   begin strobe.loadEn  = 1'b1; strobe.kind = KIND_HALF; strobe.signExt = 1'b1; end
        OP_LHU:  begin strobe.loadEn  = 1'b1; strobe.kind = KIND_HALF; end
        OP_LW:   begin strobe.loadEn  = 1'b1; strobe.kind = KIND_WORD; end
        OP_LWL:  begin strobe.loadEn  = 1'b1; strobe.kind = KIND_LEFT; end
        OP_LWR:  begin strobe.loadEn  = 1'b1; strobe.kind = KIND_RIGHT; end
        OP_SB:   begin strobe.storeEn = 1'b1; strobe.kind = KIND_BYTE; end
        OP_SH:   begin strobe.storeEn = 1'b1; strobe.kind = KIND_HALF; end
        OP_SW:   begin strobe.storeEn = 1'b1; strobe.kind = KIND_WORD; end
        OP_SWL:  begin strobe.storeEn = 1'b1; strobe.kind = KIND_LEFT; end
        OP_SWR:  begin strobe.storeEn = 1'b1; strobe.kind = KIND_RIGHT; end
        default: strobe.badOp = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lsAlignData.sv
module lsAlignData
  import lsAlignPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [XLEN-1:0]   baseVal,
  input  logic [IMM_W-1:0]  imm,
  input  logic [RIDX_W-1:0] rtSel,
  input  logic [XLEN-1:0]   rtVal,
  input  logic [XLEN-1:0]   memWord,
  output logic              validOut,
  output logic [XLEN-1:0]   effAddr,
  output logic [XLEN-1:0]   wordAddr,
  output logic [RIDX_W-1:0] rtIdx,
  output logic              regWe,
  output logic [XLEN-1:0]   regData,
  output logic              memWe,
  output logic [XLEN-1:0]   memData,
  output logic [NBYTES-1:0] byteEn,
  output logic              illegal
);
  localparam logic [NBYTES-1:0] LANES_ALL = '1;
  localparam logic [NBYTES-1:0] LANE_ONE  = NBYTES'(1);
  localparam logic [NBYTES-1:0] HALF_LO   = LANES_ALL >> (NBYTES / 2);
  localparam logic [XLEN-1:0]   BITS_ALL  = '1;
  localparam int                HALF_W    = XLEN / 2;

  logic [XLEN-1:0]   addrNow;
  logic [OFF_W-1:0]  offNow;
  logic [OFF_W-1:0]  revOff;
  logic [SH_W-1:0]   offShift;
  logic [SH_W-1:0]   revShift;
  logic [SH_W-1:0]   halfShift;
  logic              hiHalf;
  logic [XLEN-1:0]   bytePick;
  logic [XLEN-1:0]   halfPick;
  logic [XLEN-1:0]   loadVal;
  logic [XLEN-1:0]   storeVal;
  logic [NBYTES-1:0] laneEn;
  logic [XLEN-1:0]   laneMask;
  logic [XLEN-1:0]   mergedWord;

  // address formation
  assign addrNow  = baseVal + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign offNow   = addrNow[OFF_W-1:0];
  assign revOff   = OFF_W'(NBYTES - 1) - offNow;
  assign offShift = {offNow, 3'b000};
  assign revShift = {revOff, 3'b000};
  assign hiHalf   = ~addrNow[OFF_W-1];
  assign halfShift = hiHalf ? SH_W'(HALF_W) : '0;

  // load extraction, big-endian lanes
  assign bytePick = memWord >> revShift;
  assign halfPick = memWord >> halfShift;

  always_comb begin
    unique case (strobe.kind)
      KIND_BYTE:  loadVal = strobe.signExt ? {{(XLEN-8){bytePick[7]}}, bytePick[7:0]}
                                           : {{(XLEN-8){1'b0}}, bytePick[7:0]};
      KIND_HALF:  loadVal = strobe.signExt ? {{(XLEN-HALF_W){halfPick[HALF_W-1]}}, halfPick[HALF_W-1:0]}
                                           : {{(XLEN-HALF_W){1'b0}}, halfPick[HALF_W-1:0]};
      KIND_LEFT:  loadVal = (memWord << offShift) | (rtVal & ~(BITS_ALL << offShift));
      KIND_RIGHT: loadVal = (memWord >> revShift) | (rtVal & ~(BITS_ALL >> revShift));
      default:    loadVal = memWord;
    endcase
  end

  // store lane placement
  always_comb begin
    unique case (strobe.kind)
      KIND_BYTE: begin
        storeVal = {NBYTES{rtVal[7:0]}};
        laneEn   = LANE_ONE << revOff;
      end
      KIND_HALF: begin
        storeVal = {2{rtVal[HALF_W-1:0]}};
        laneEn   = hiHalf ? ~HALF_LO : HALF_LO;
      end
      KIND_LEFT: begin
        storeVal = rtVal >> offShift;
        laneEn   = LANES_ALL >> offNow;
      end
      KIND_RIGHT: begin
        storeVal = rtVal << revShift;
        laneEn   = LANES_ALL << revOff;
      end
      default: begin
        storeVal = rtVal;
        laneEn   = LANES_ALL;
      end
    endcase
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign laneMask[8*g +: 8] = {8{laneEn[g]}};
  end

  assign mergedWord = (storeVal & laneMask) | (memWord & ~laneMask);

  // result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      effAddr  <= '0;
      wordAddr <= '0;
      rtIdx    <= '0;
      regWe    <= 1'b0;
      regData  <= '0;
      memWe    <= 1'b0;
      memData  <= '0;
      byteEn   <= '0;
      illegal  <= 1'b0;
    end else begin
      validOut <= strobe.active;
      effAddr  <= addrNow;
      wordAddr <= {addrNow[XLEN-1:OFF_W], {OFF_W{1'b0}}};
      rtIdx    <= rtSel;
      regWe    <= strobe.loadEn;
      regData  <= strobe.loadEn ? loadVal : '0;
      memWe    <= strobe.storeEn;
      memData  <= strobe.storeEn ? mergedWord : '0;
      byteEn   <= strobe.storeEn ? laneEn : '0;
      illegal  <= strobe.badOp;
    end
  end
endmodule

// File: rtl/lsAligner.sv
module lsAligner
  import lsAlignPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validIn,
  input  logic [31:0] insn,
  input  logic [31:0] baseVal,
  input  logic [31:0] rtVal,
  input  logic [31:0] memWord,
  output logic        validOut,
  output logic [31:0] effAddr,
  output logic [31:0] wordAddr,
  output logic [4:0]  rtIdx,
  output logic        regWe,
  output logic [31:0] regData,
  output logic        memWe,
  output logic [31:0] memData,
  output logic [3:0]  byteEn,
  output logic        illegal
);
  ctrlStrobe_t strobe;

  lsAlignCtrl u_ctrl (
    .validIn (validIn),
    .opcode  (insn[31:26]),
    .strobe  (strobe)
  );

  lsAlignData u_data (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .baseVal  (baseVal),
    .imm      (insn[15:0]),
    .rtSel    (insn[20:16]),
    .rtVal    (rtVal),
    .memWord  (memWord),
    .validOut (validOut),
    .effAddr  (effAddr),
    .wordAddr (wordAddr),
    .rtIdx    (rtIdx),
    .regWe    (regWe),
    .regData  (regData),
    .memWe    (memWe),
    .memData  (memData),
    .byteEn   (byteEn),
    .illegal  (illegal)
  );
endmodule

// File: rtl/lsAlignChk.sv
module lsAlignChk
  import lsAlignPkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        validIn,
  input logic [31:0] insn,
  input logic        validOut,
  input logic [31:0] effAddr,
  input logic [31:0] wordAddr,
  input logic        regWe,
  input logic        memWe,
  input logic [3:0]  byteEn,
  input logic        illegal
);
  a_r11_valid_follow: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);

  a_r11_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> (!regWe && !memWe && !illegal && byteEn == 4'b0000));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({regWe, memWe, illegal}));

  a_r10_illegal_pulse: assert property (@(posedge clk) disable iff (rst)
    (illegal && !validIn) |=> !illegal);

  a_r7_lanes_with_store: assert property (@(posedge clk) disable iff (rst)
    memWe |-> byteEn != 4'b0000);

  a_r7_byte_single_lane: assert property (@(posedge clk) disable iff (rst)
    (validIn && insn[31:26] == OP_SB) |=> $countones(byteEn) == 1);

  a_r8_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (validIn && insn[31:26] == OP_SW) |=> byteEn == 4'b1111);

  a_r1_word_align: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (wordAddr[1:0] == 2'b00 && wordAddr[31:2] == effAddr[31:2]));
endmodule

bind lsAligner lsAlignChk u_chk (
  .clk      (clk),
  .rst      (rst),
  .validIn  (validIn),
  .insn     (insn),
  .validOut (validOut),
  .effAddr  (effAddr),
  .wordAddr (wordAddr),
  .regWe    (regWe),
  .memWe    (memWe),
  .byteEn   (byteEn),
  .illegal  (illegal)
);

// File: tb/test_lsAligner.sv
module test_lsAligner;
  logic        clk = 1'b0;
  logic        rst;
  logic        validIn;
  logic [31:0] insn, baseVal, rtVal, memWord;
  logic        validOut, regWe, memWe, illegal;
  logic [31:0] effAddr, wordAddr, regData, memData;
  logic [4:0]  rtIdx;
  logic [3:0]  byteEn;
  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lsAligner i_lsAligner (
    .clk(clk), .rst(rst), .validIn(validIn), .insn(insn), .baseVal(baseVal),
    .rtVal(rtVal), .memWord(memWord), .validOut(validOut), .effAddr(effAddr),
    .wordAddr(wordAddr), .rtIdx(rtIdx), .regWe(regWe), .regData(regData),
    .memWe(memWe), .memData(memData), .byteEn(byteEn), .illegal(illegal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // present one access at a falling edge, return after the next falling edge
  task automatic issue(input logic [5:0] op, input logic [31:0] base, input logic [15:0] imm,
                       input logic [31:0] rt, input logic [31:0] mem);
    @(negedge clk);
    validIn = 1'b1;
    insn    = {op, 5'd9, 5'd8, imm};
    baseVal = base;
    rtVal   = rt;
    memWord = mem;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  task automatic expectLoad(input string req, input logic [31:0] exp);
    chk(req, "validOut", {31'b0, validOut}, 32'd1);
    chk(req, "regWe", {31'b0, regWe}, 32'd1);
    chk(req, "memWe", {31'b0, memWe}, 32'd0);
    chk(req, "regData", regData, exp);
  endtask

  task automatic expectStore(input string req, input logic [31:0] exp, input logic [3:0] en);
    chk(req, "memWe", {31'b0, memWe}, 32'd1);
    chk(req, "regWe", {31'b0, regWe}, 32'd0);
    chk(req, "byteEn", {28'b0, byteEn}, {28'b0, en});
    chk(req, "memData", memData, exp);
  endtask

  task automatic testReset;
    chk("R12", "validOut", {31'b0, validOut}, 32'd0);
    chk("R12", "strobes", {29'b0, regWe, memWe, illegal}, 32'd0);
    chk("R12", "byteEn", {28'b0, byteEn}, 32'd0);
    chk("R12", "regData", regData, 32'd0);
    chk("R12", "memData", memData, 32'd0);
  endtask

  task automatic testAddress;
    issue(6'h23, 32'h100, 16'hFFFD, 32'h0, 32'h11223344);
    chk("R1", "effAddr", effAddr, 32'h0FD);
    chk("R1", "wordAddr", wordAddr, 32'h0FC);
    chk("R1", "rtIdx", {27'b0, rtIdx}, 32'd8);
    expectLoad("R4", 32'h11223344);
    issue(6'h23, 32'h100, 16'h0006, 32'h0, 32'hCAFEF00D);
    chk("R1", "effAddr pos", effAddr, 32'h106);
    chk("R1", "wordAddr pos", wordAddr, 32'h104);
    expectLoad("R4", 32'hCAFEF00D);
  endtask

  task automatic testByteLoads;
    issue(6'h20, 32'h100, 16'h4, 32'h0, 32'h12000000);
    expectLoad("R2", 32'h00000012);
    issue(6'h20, 32'h100, 16'h6, 32'h0, 32'h0000F000);
    expectLoad("R2", 32'hFFFFFFF0);
    issue(6'h24, 32'h100, 16'h6, 32'h0, 32'h0000F000);
    expectLoad("R2", 32'h000000F0);
    issue(6'h20, 32'h100, 16'h7, 32'h0, 32'h00000080);
    expectLoad("R2", 32'hFFFFFF80);
  endtask

  task automatic testHalfLoads;
    issue(6'h21, 32'h100, 16'h4, 32'h0, 32'h12230000);
    expectLoad("R3", 32'h00001223);
    issue(6'h21, 32'h100, 16'h7, 32'h0, 32'h00008001);
    expectLoad("R3", 32'hFFFF8001);
    issue(6'h25, 32'h100, 16'h6, 32'h0, 32'h00008001);
    expectLoad("R3", 32'h00008001);
    issue(6'h25, 32'h100, 16'h5, 32'h0, 32'hBEEF0000);
    expectLoad("R3", 32'h0000BEEF);
  endtask

  task automatic testLoadLeft;
    issue(6'h22, 32'h100, 16'h4, 32'hAABBCCDD, 32'h12345678);
    expectLoad("R5", 32'h12345678);
    issue(6'h22, 32'h100, 16'h5, 32'hAABBCCDD, 32'h12345678);
    expectLoad("R5", 32'h345678DD);
    issue(6'h22, 32'h100, 16'h7, 32'hAABBCCDD, 32'h12345678);
    expectLoad("R5", 32'h78BBCCDD);
  endtask

  task automatic testLoadRight;
    issue(6'h26, 32'h100, 16'h4, 32'hAABBCCDD, 32'h12345678);
    expectLoad("R6", 32'hAABBCC12);
    issue(6'h26, 32'h100, 16'h5, 32'hAABBCCDD, 32'h12345678);
    expectLoad("R6", 32'hAABB1234);
    issue(6'h26, 32'h100, 16'h7, 32'hAABBCCDD, 32'h12345678);
    expectLoad("R6", 32'h12345678);
  endtask

  task automatic testSmallStores;
    issue(6'h28, 32'h100, 16'h4, 32'hAABBCCDD, 32'h11223344);
    expectStore("R7", 32'hDD223344, 4'b1000);
    issue(6'h28, 32'h100, 16'h6, 32'hAABBCCDD, 32'h11223344);
    expectStore("R7", 32'h1122DD44, 4'b0010);
    issue(6'h29, 32'h100, 16'h4, 32'hAABBCCDD, 32'h11223344);
    expectStore("R7", 32'hCCDD3344, 4'b1100);
    issue(6'h29, 32'h100, 16'h6, 32'hAABBCCDD, 32'h11223344);
    expectStore("R7", 32'h1122CCDD, 4'b0011);
  endtask

  task automatic testWordLeftStores;
    issue(6'h2b, 32'h100, 16'h4, 32'hAABBCCDD, 32'h11223344);
    expectStore("R8", 32'hAABBCCDD, 4'b1111);
    issue(6'h2a, 32'h100, 16'h4, 32'hAABBCCDD, 32'h11223344);
    expectStore("R8", 32'hAABBCCDD, 4'b1111);
    issue(6'h2a, 32'h100, 16'h5, 32'hAABBCCDD, 32'h11223344);
    expectStore("R8", 32'h11AABBCC, 4'b0111);
    issue(6'h2a, 32'h100, 16'h6, 32'hAABBCCDD, 32'h11223344);
    expectStore("R8", 32'h1122AABB, 4'b0011);
  endtask

  task automatic testRightStores;
    issue(6'h2e, 32'h100, 16'h5, 32'hAABBCCDD, 32'h00000000);
    expectStore("R9", 32'hCCDD0000, 4'b1100);
    issue(6'h2e, 32'h100, 16'h4, 32'hAABBCCDD, 32'h11223344);
    expectStore("R9", 32'hDD223344, 4'b1000);
    issue(6'h2e, 32'h100, 16'h7, 32'hAABBCCDD, 32'h11223344);
    expectStore("R9", 32'hAABBCCDD, 4'b1111);
  endtask

  task automatic testIllegal;
    issue(6'h27, 32'h100, 16'h4, 32'hAABBCCDD, 32'h11223344);
    chk("R10", "illegal", {31'b0, illegal}, 32'd1);
    chk("R10", "we pair", {30'b0, regWe, memWe}, 32'd0);
    chk("R10", "byteEn", {28'b0, byteEn}, 32'd0);
    @(negedge clk);
    chk("R10", "illegal drops", {31'b0, illegal}, 32'd0);
    issue(6'h2c, 32'h100, 16'h4, 32'hAABBCCDD, 32'h11223344);
    chk("R10", "illegal 0x2c", {31'b0, illegal}, 32'd1);
    chk("R10", "we pair 0x2c", {30'b0, regWe, memWe}, 32'd0);
  endtask

  task automatic testHandshake;
    @(negedge clk);
    chk("R11", "idle validOut", {31'b0, validOut}, 32'd0);
    chk("R11", "idle strobes", {29'b0, regWe, memWe, illegal}, 32'd0);
    chk("R11", "idle byteEn", {28'b0, byteEn}, 32'd0);
    issue(6'h28, 32'h100, 16'h4, 32'hAABBCCDD, 32'h0);
    chk("R11", "validOut after store", {31'b0, validOut}, 32'd1);
    @(negedge clk);
    chk("R11", "validOut single", {31'b0, validOut}, 32'd0);
    chk("R11", "memWe single", {31'b0, memWe}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; validIn = 1'b0; insn = '0; baseVal = '0; rtVal = '0; memWord = '0;
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    testAddress();
    testByteLoads();
    testHalfLoads();
    testLoadLeft();
    testLoadRight();
    testSmallStores();
    testWordLeftStores();
    testRightStores();
    testIllegal();
    testHandshake();
    // reset in the middle of activity clears the outputs again
    issue(6'h2b, 32'h100, 16'h4, 32'hAABBCCDD, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    testReset();
    rst = 1'b0;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule